// File: doc/BRIEF.md
# Byte-Command Parallel Port Expander

This block turns a stream of command bytes from a host into control of 48 general-purpose pins. The pins form six 8-bit ports. The host reaches the block through a byte FIFO interface with two handshakes. One says that a received byte is waiting to be taken, and the other says that the transmit side can accept a byte. Each pin has its own value register, its own direction register and a tristate driver. The pad itself is modelled as three signals: the driven level, an output enable and the sensed level.

A command byte holds a port index in its low three bits and an operation in its top five bits. Set-value and set-direction commands each take one trailing data byte. A get-value command takes no data byte and sends one reply byte back, which holds the synchronized levels of the selected port's pins. The host can send commands back to back in one burst, and they run strictly in arrival order. It can also send several reads before it collects any reply, and the replies come back in the order of the reads.

The parser is a three-state machine:
- `ST_CMD` waits for and consumes a command byte.
- `ST_ARG` consumes the data byte of a write.
- `ST_REPLY` holds a reply until the transmit side is ready.

Its transitions are:
- `ST_CMD`→`ST_ARG` on a set-value or set-direction command.
- `ST_CMD`→`ST_REPLY` on a get-value command with a valid port.
- `ST_CMD`→`ST_CMD` on any other command byte, which is dropped.
- `ST_ARG`→`ST_CMD` once the data byte is consumed.
- `ST_REPLY`→`ST_CMD` once the reply is pushed.

Top module: `byte_port_expander`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` all 0), every output register is 0 (`pin_out` all 0), and no reply is pushed.
- R2: In a command byte, bits [2:0] select the port and bits [7:3] select the operation: 0 is get value, 1 is set value, 2 is set direction. Port p owns pins 8p to 8p+7, and bit b of a data or reply byte maps to pin 8p+b.
- R3: A set-value command writes its data byte into the selected port's output register, and that value appears on `pin_out`. Other ports keep their values.
- R4: A set-direction command writes its data byte into the selected port's direction register. A 0 bit enables the pin's driver (`pin_oe`=1). A 1 bit makes the pin an input with its driver in high impedance (`pin_oe`=0).
- R5: A get-value command on a valid port pushes exactly one reply byte, made of that port's pin levels after a two-flop synchronizer.
- R6: Commands run strictly in arrival order with no turnaround between them. A set-low followed at once by a set-high on the same driven pin gives a low pulse of at least one cycle, and the pin ends high.
- R7: Several get-value commands sent before any reply is collected return their replies in command order.
- R8: Port indices 6 and 7 are ignored. A write to one of them still consumes its data byte, and a read of one produces no reply.
- R9: A reply is pushed only while `tx_ready` is high. While a reply waits, `tx_data` stays stable and no further bytes are consumed.
- R10: A command byte whose operation field is not 0, 1 or 2 is consumed on its own, with no effect and no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | A received byte is available |
| rx_data | input | 8 | Received byte |
| rx_pop | output | 1 | Consume the received byte this cycle |
| tx_ready | input | 1 | The transmit side can take a byte |
| tx_data | output | 8 | Reply byte |
| tx_push | output | 1 | Push `tx_data` this cycle |
| pin_in | input | 48 | Sensed pin levels |
| pin_out | output | 48 | Driven pin levels |
| pin_oe | output | 48 | Per-pin driver enable |

## Verification
The bench loops driven pins back into `pin_in` and feeds input pins from an external level vector, so a read tells a driven output apart from an input pin.

It sends several kinds of burst:
- Single writes per port, including a partial direction mask, which show the bit and port mapping.
- A back-to-back low/high pair on one pin, which shows strict ordering and the absence of turnaround.
- Three reads queued while the transmit side is not ready. These separate the reply ordering from the stall behaviour.
- Bursts with out-of-range ports or undefined operations followed by a valid command. These show whether the parser stays aligned with the byte stream.

// File: rtl/pex_pkg.sv
package pex_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 3;
    localparam int OP_W   = BYTE_W - IDX_W;

    localparam logic [OP_W-1:0] OP_GET     = 5'd0;
    localparam logic [OP_W-1:0] OP_SET_VAL = 5'd1;
    localparam logic [OP_W-1:0] OP_SET_DIR = 5'd2;

    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_ARG   = 2'd1,
        ST_REPLY = 2'd2
    } pex_state_e;
endpackage

// File: rtl/pex_sync.sv
module pex_sync #(
    parameter int WIDTH  = 48,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/pex_port_regs.sv
module pex_port_regs import pex_pkg::*; #(
    parameter int NUM_PORTS = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic                        wr_dir,
    input  logic [IDX_W-1:0]            wr_port,
    input  logic [BYTE_W-1:0]           wr_data,
    output logic [NUM_PORTS*BYTE_W-1:0] val_q,
    output logic [NUM_PORTS*BYTE_W-1:0] dir_q
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit = wr_en && (wr_port == IDX_W'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q[p*BYTE_W +: BYTE_W] <= '0;
                dir_q[p*BYTE_W +: BYTE_W] <= '1;
            end else if (hit) begin
                if (wr_dir) dir_q[p*BYTE_W +: BYTE_W] <= wr_data;
                else        val_q[p*BYTE_W +: BYTE_W] <= wr_data;
            end
        end

        // R3: a port that is not addressed keeps its registers
        a_r3_other_ports_hold: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_port == IDX_W'(p)) |=>
                $stable(val_q[p*BYTE_W +: BYTE_W]) && $stable(dir_q[p*BYTE_W +: BYTE_W]));
    end

    // R1: reset leaves all pins as inputs with zero output values
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (&dir_q) && (val_q == '0));
endmodule

// File: rtl/pex_parser.sv
module pex_parser import pex_pkg::*; #(
    parameter int NUM_PORTS = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rx_valid,
    input  logic [BYTE_W-1:0]           rx_data,
    output logic                        rx_pop,
    input  logic                        tx_ready,
    output logic [BYTE_W-1:0]           tx_data,
    output logic                        tx_push,
    input  logic [NUM_PORTS*BYTE_W-1:0] pin_lvl,
    output logic                        wr_en,
    output logic                        wr_dir,
    output logic [IDX_W-1:0]            wr_port,
    output logic [BYTE_W-1:0]           wr_data
);
    pex_state_e state_q, state_d;

    logic [IDX_W-1:0]  port_q;
    logic              isdir_q;
    logic [BYTE_W-1:0] reply_q;

    logic [IDX_W-1:0]  cmd_port;
    logic [OP_W-1:0]   cmd_op;
    logic              cmd_port_ok;
    logic              held_port_ok;
    logic [BYTE_W-1:0] sel_lvl;

    assign cmd_port     = rx_data[IDX_W-1:0];
    assign cmd_op       = rx_data[BYTE_W-1:IDX_W];
    assign cmd_port_ok  = 32'(cmd_port) < NUM_PORTS;
    assign held_port_ok = 32'(port_q) < NUM_PORTS;

    always_comb begin
        sel_lvl = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (cmd_port == IDX_W'(p)) sel_lvl = pin_lvl[p*BYTE_W +: BYTE_W];
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_CMD;
        else     state_q <= state_d;
    end

    // command capture
    always_ff @(posedge clk) begin
        if (rst) begin
            port_q  <= '0;
            isdir_q <= 1'b0;
            reply_q <= '0;
        end else if (state_q == ST_CMD && rx_valid) begin
            port_q  <= cmd_port;
            isdir_q <= (cmd_op == OP_SET_DIR);
            reply_q <= sel_lvl;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CMD: begin
                if (rx_valid) begin
                    if (cmd_op == OP_SET_VAL || cmd_op == OP_SET_DIR) state_d = ST_ARG;
                    else if (cmd_op == OP_GET && cmd_port_ok)         state_d = ST_REPLY;
                end
            end
            ST_ARG:   if (rx_valid) state_d = ST_CMD;
            ST_REPLY: if (tx_ready) state_d = ST_CMD;
            default:  state_d = ST_CMD;
        endcase
    end

    // outputs
    always_comb begin
        rx_pop  = 1'b0;
        tx_push = 1'b0;
        wr_en   = 1'b0;
        unique case (state_q)
            ST_CMD:   rx_pop = rx_valid;
            ST_ARG: begin
                rx_pop = rx_valid;
                wr_en  = rx_valid && held_port_ok;
            end
            ST_REPLY: tx_push = tx_ready;
            default: ;
        endcase
    end

    assign wr_dir  = isdir_q;
    assign wr_port = port_q;
    assign wr_data = rx_data;
    assign tx_data = reply_q;

    a_r9_push_needs_ready: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> tx_ready);
    a_r9_no_pop_in_reply: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REPLY) |-> !rx_pop);
    a_r9_reply_held: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REPLY && !tx_ready) |=> $stable(tx_data) && state_q == ST_REPLY);
    a_r2_pop_only_valid: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> rx_valid);
    a_r8_no_write_bad_port: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (32'(wr_port) < NUM_PORTS));
endmodule

// File: rtl/byte_port_expander.sv
module byte_port_expander import pex_pkg::*; #(
    parameter int NUM_PORTS   = 6,
    parameter int SYNC_STAGES = 2,
    localparam int PIN_W      = NUM_PORTS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_pop,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_push,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    logic [PIN_W-1:0]  pin_lvl;
    logic [PIN_W-1:0]  val_q;
    logic [PIN_W-1:0]  dir_q;
    logic              wr_en;
    logic              wr_dir;
    logic [IDX_W-1:0]  wr_port;
    logic [BYTE_W-1:0] wr_data;

    pex_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d_in (pin_in),
        .d_out(pin_lvl)
    );

    pex_parser #(.NUM_PORTS(NUM_PORTS)) u_parser (
        .clk     (clk),
        .rst     (rst),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .rx_pop  (rx_pop),
        .tx_ready(tx_ready),
        .tx_data (tx_data),
        .tx_push (tx_push),
        .pin_lvl (pin_lvl),
        .wr_en   (wr_en),
        .wr_dir  (wr_dir),
        .wr_port (wr_port),
        .wr_data (wr_data)
    );

    pex_port_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_dir (wr_dir),
        .wr_port(wr_port),
        .wr_data(wr_data),
        .val_q  (val_q),
        .dir_q  (dir_q)
    );

    assign pin_out = val_q;
    assign pin_oe  = ~dir_q;

    // R4: an enabled driver always belongs to a pin that is not an input
    a_r4_oe_matches_dir: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & dir_q) == '0);
endmodule

// File: tb/test_byte_port_expander.sv
module test_byte_port_expander;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_pop;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        tx_push;
    logic [47:0] pin_in;
    logic [47:0] pin_out;
    logic [47:0] pin_oe;
    logic [47:0] ext = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] hq [256];
    int hw = 0;
    int hr = 0;
    logic [7:0] rq [256];
    int rcnt = 0;
    bit mon_en = 1'b0;
    int low_cycles = 0;

    always #4 clk = ~clk;

    assign rx_valid = (hr != hw);
    assign rx_data  = hq[hr[7:0]];
    assign pin_in   = (pin_oe & pin_out) | (~pin_oe & ext);

    always @(posedge clk) begin
        if (rx_pop) hr <= hr + 1;
        if (tx_push) begin
            rq[rcnt[7:0]] <= tx_data;
            rcnt <= rcnt + 1;
        end
        if (mon_en && pin_oe[8] && !pin_out[8]) low_cycles <= low_cycles + 1;
    end

    byte_port_expander i_byte_port_expander (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_push(tx_push),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        hq[hw[7:0]] = b;
        hw++;
    endtask

    task automatic drain();
        @(negedge clk);
        while (hr != hw) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(pin_oe == '0, "R1 oe", 64'(pin_oe), 0);
        chk(pin_out == '0, "R1 out", 64'(pin_out), 0);
        chk(!tx_push && rcnt == 0, "R1 push", 64'(rcnt), 0);
    endtask

    task automatic t_write_basic();
        send(8'h10); send(8'h00);
        send(8'h08); send(8'hA5);
        drain();
        chk(pin_out == 48'h0000_0000_00A5, "R3 out", 64'(pin_out), 64'h00A5);
        chk(pin_oe == 48'h0000_0000_00FF, "R4 oe", 64'(pin_oe), 64'h00FF);
        send(8'h13); send(8'h0F);
        drain();
        chk(pin_oe[31:24] == 8'hF0, "R4 partial", 64'(pin_oe[31:24]), 64'hF0);
        send(8'h15); send(8'h00);
        send(8'h0D); send(8'h81);
        drain();
        chk(pin_out[47:40] == 8'h81 && pin_oe[47:40] == 8'hFF, "R2 port5",
            64'({pin_oe[47:40], pin_out[47:40]}), 64'hFF81);
    endtask

    task automatic t_read();
        int base;
        ext[23:16] = 8'h3C;
        ext[31:24] = 8'hFF;
        repeat (4) @(negedge clk);
        base = rcnt;
        send(8'h02); send(8'h00);
        drain();
        chk(rcnt == base + 2, "R5 count", 64'(rcnt - base), 2);
        chk(rq[base[7:0]] == 8'h3C, "R5 input", 64'(rq[base[7:0]]), 64'h3C);
        chk(rq[8'(base + 1)] == 8'hA5, "R5 loopback", 64'(rq[8'(base + 1)]), 64'hA5);
        ext[23:16] = 8'hC3;
        repeat (4) @(negedge clk);
        send(8'h02);
        drain();
        chk(rq[8'(base + 2)] == 8'hC3, "R5 sync", 64'(rq[8'(base + 2)]), 64'hC3);
    endtask

    task automatic t_queue();
        int base;
        int hr0;
        base = rcnt;
        hr0 = hr;
        tx_ready = 1'b0;
        send(8'h00); send(8'h02); send(8'h03);
        repeat (8) @(negedge clk);
        chk(rcnt == base && !tx_push, "R9 no push", 64'(rcnt - base), 0);
        chk(hr == hr0 + 1, "R9 stall", 64'(hr - hr0), 1);
        chk(tx_data == 8'hA5, "R9 held", 64'(tx_data), 64'hA5);
        tx_ready = 1'b1;
        drain();
        chk(rcnt == base + 3, "R7 count", 64'(rcnt - base), 3);
        chk({rq[base[7:0]], rq[8'(base + 1)], rq[8'(base + 2)]} == 24'hA5C30F, "R7 order",
            64'({rq[base[7:0]], rq[8'(base + 1)], rq[8'(base + 2)]}), 64'hA5C30F);
    endtask

    task automatic t_pulse();
        send(8'h11); send(8'h00);
        send(8'h09); send(8'hFF);
        drain();
        low_cycles = 0;
        mon_en = 1'b1;
        send(8'h09); send(8'hFE);
        send(8'h09); send(8'hFF);
        drain();
        mon_en = 1'b0;
        chk(low_cycles >= 1, "R6 pulse", 64'(low_cycles), 1);
        chk(pin_out[8] == 1'b1, "R6 end high", 64'(pin_out[8]), 1);
    endtask

    task automatic t_bad_port();
        logic [47:0] out0, oe0;
        int base;
        out0 = pin_out;
        oe0 = pin_oe;
        send(8'h0E); send(8'hAA);
        send(8'h08); send(8'h55);
        drain();
        chk(pin_out == ((out0 & ~48'hFF) | 48'h55), "R8 aligned", 64'(pin_out), 64'((out0 & ~48'hFF) | 48'h55));
        send(8'h17); send(8'h00);
        drain();
        chk(pin_oe == oe0, "R8 dir ignored", 64'(pin_oe), 64'(oe0));
        base = rcnt;
        send(8'h07); send(8'h00);
        drain();
        chk(rcnt == base + 1 && rq[base[7:0]] == 8'h55, "R8 no reply",
            64'({rcnt - base, 24'(rq[base[7:0]])}), 64'h1_000055);
    endtask

    task automatic t_bad_op();
        int base;
        send(8'h18);
        send(8'h08); send(8'h11);
        drain();
        chk(pin_out[7:0] == 8'h11, "R10 consumed", 64'(pin_out[7:0]), 64'h11);
        base = rcnt;
        send(8'hF8); send(8'h00);
        drain();
        chk(rcnt == base + 1 && rq[base[7:0]] == 8'h11, "R10 no reply",
            64'({rcnt - base, 24'(rq[base[7:0]])}), 64'h1_000011);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) hq[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_write_basic();
        t_read();
        t_queue();
        t_pulse();
        t_bad_port();
        t_bad_op();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule